// File: doc/BRIEF.md
# Line-Interface Event Debounce and Interrupt

This block watches the status outputs of two subscriber line-interface channels. Each channel provides an active-low detector line and an active-low thermal-alarm line. A change of line state is signalled when one of these lines goes from 1 to 0. All four lines are asynchronous to the block clock, so they pass through two-flop synchronizers before the block looks for edges. The block keeps a readable status bit for each line and drives one shared active-low interrupt output.

Detector lines are filtered. A falling edge starts a per-channel debounce hold whose length is set by a 4-bit field, counted in ticks of a shared prescaler. During the hold, the detector status bit and the interrupt keep the values they had before the edge. At the end of the hold, the line is sampled again and the result is taken. Alarm lines are not filtered.

In normal operation, a falling edge raises the interrupt only if all four lines were high just before the edge. When the power-down pin is low, the debounce is switched off and any falling edge on any of the four lines raises the interrupt. The interrupt is released once all four lines are high again and no hold is running.

Top module: `line_evt_irq`

## Requirements
- R1: After reset, the interrupt output is 1 and all four status bits read as 1.
- R2: A channel's alarm status bit equals its synchronized alarm pin: 1 when the pin is 1, 0 when it is 0. It updates 3 clock edges after the pin changes. The read port returns `{alm1, det1, alm0, det0}` on `rd_data_o[3:0]`, one edge after `rd_en_i` is sampled high, and holds that value otherwise.
- R3: With the power-down pin high, if an alarm line falls while all four lines were 1, the interrupt output goes to 0 on the 3rd clock edge after the pin change, and not earlier.
- R4: With the power-down pin high, a falling edge on any line raises no interrupt if any of the four lines was already 0 just before that edge.
- R5: With the power-down pin high, a detector fall starts a hold on that channel. The hold ends on the (setting+1)-th prescaler tick after it starts. Until the hold ends, the channel's detector status bit and the interrupt output stay unchanged, whatever the pin does.
- R6: When a hold ends, the detector status bit takes the synchronized pin level at that moment. If that level is 0 and all four lines were 1 when the hold started, the interrupt goes to 0. A pulse that ends before the hold ends leaves the status bit at 1 and raises no interrupt.
- R7: With the power-down pin low, a falling edge on any of the four lines drives the interrupt output to 0, even if another line is already 0.
- R8: With the power-down pin low, no debounce is applied. A running hold is cancelled, and the detector status bit follows its synchronized pin with the same 3-edge delay as the alarm status bit.
- R9: The interrupt output returns to 1 on the next clock edge once all four synchronized lines are 1 and no hold is running.
- R10: Each channel takes its hold length from its own 4-bit field in `deb_cfg_i`, with channel c in bits [4c+3:4c]. Two channels whose holds start together end them after their own lengths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_n_i | input | 2 | Detector lines, active low, asynchronous |
| alm_n_i | input | 2 | Thermal-alarm lines, active low, asynchronous |
| pdn_n_i | input | 1 | Power-down, active low: 0 selects power-down behaviour |
| deb_cfg_i | input | 8 | Per-channel debounce setting, 4 bits per channel |
| rd_en_i | input | 1 | Status read strobe |
| rd_data_o | output | 4 | Captured status bits {alm1, det1, alm0, det0} |
| irq_n_o | output | 1 | Shared interrupt, active low |

## Verification
A pin change reaches the interrupt and the status registers on the 3rd clock edge after it. A read strobe adds one more edge. Debounce expiries land within one prescaler period of (setting+1) ticks after the hold starts. The bench changes pins and samples at falling clock edges. It checks the 3-edge result exactly, and also checks that the result is not yet there after 2 edges. Debounce results are sampled only at points that lie safely before the earliest possible expiry or after the latest possible expiry, so the prescaler phase cannot change the outcome.

// File: rtl/line_evt_pkg.sv
package line_evt_pkg;
   // One channel's readable status, packed as {alm, det}
   typedef struct packed {
      logic alm;
      logic det;
   } chan_stat_t;

   localparam int unsigned STAT_W = $bits(chan_stat_t);
endpackage

// File: rtl/lei_sync.sv
module lei_sync #(
   parameter int unsigned W     = 1,
   parameter int unsigned DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("lei_sync: DEPTH must be at least 2");
      end
   endgenerate

   logic [W-1:0] stage_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) stage_q[i] <= '1;
      end else begin
         stage_q[0] <= d_i;
         for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q_o = stage_q[DEPTH-1];
endmodule

// File: rtl/lei_tick.sv
module lei_tick #(
   parameter int unsigned DIV = 200000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   generate
      if (DIV < 1) begin : g_bad_div
         $error("lei_tick: DIV must be at least 1");
      end else if (DIV == 1) begin : g_every
         assign tick_o = 1'b1;
      end else begin : g_count
         localparam int unsigned CW = $clog2(DIV);
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (cnt_q == LAST)  cnt_q <= '0;
            else                     cnt_q <= cnt_q + 1'b1;
         end

         assign tick_o = (cnt_q == LAST);

         // tick is a single-cycle pulse (supports R5 timing)
         p_tick_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
            tick_o |=> !tick_o);
      end
   endgenerate
endmodule

// File: rtl/lei_debounce.sv
module lei_debounce #(
   parameter int unsigned CFG_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             pdn_act_i,
   input  logic             det_lvl_i,
   input  logic             det_fall_i,
   input  logic             qual_i,
   input  logic [CFG_W-1:0] cfg_i,
   output logic             det_stat_o,
   output logic             hold_o,
   output logic             evt_o
);
   logic             active_q;
   logic             qual_q;
   logic [CFG_W-1:0] cnt_q;
   logic             stat_q;
   logic             expire;

   assign expire = !pdn_act_i && active_q && tick_i && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         qual_q   <= 1'b0;
         cnt_q    <= '0;
         stat_q   <= 1'b1;
      end else if (pdn_act_i) begin
         active_q <= 1'b0;
         stat_q   <= det_lvl_i;
      end else if (active_q) begin
         if (tick_i) begin
            if (cnt_q == '0) begin
               active_q <= 1'b0;
               stat_q   <= det_lvl_i;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end else if (det_fall_i) begin
         active_q <= 1'b1;
         cnt_q    <= cfg_i;
         qual_q   <= qual_i;
      end else begin
         stat_q <= det_lvl_i;
      end
   end

   assign det_stat_o = stat_q;
   assign hold_o     = active_q;
   assign evt_o      = expire && !det_lvl_i && qual_q;

   p_hold_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!pdn_act_i && !active_q && det_fall_i) |=> active_q);

   p_hold_keeps_stat_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!pdn_act_i && active_q && !tick_i) |=> $stable(stat_q));

   p_pdn_cancels_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pdn_act_i |=> !active_q);
endmodule

// File: rtl/line_evt_irq.sv
module line_evt_irq
   import line_evt_pkg::*;
#(
   parameter int unsigned NUM_CH   = 2,
   parameter int unsigned CFG_W    = 4,
   parameter int unsigned TICK_DIV = 200000,
   parameter int unsigned SYNC_D   = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_CH-1:0]         det_n_i,
   input  logic [NUM_CH-1:0]         alm_n_i,
   input  logic                      pdn_n_i,
   input  logic [NUM_CH*CFG_W-1:0]   deb_cfg_i,
   input  logic                      rd_en_i,
   output logic [NUM_CH*STAT_W-1:0]  rd_data_o,
   output logic                      irq_n_o
);
   localparam int unsigned NIN = 2 * NUM_CH;

   generate
      if (NUM_CH < 1 || CFG_W < 1) begin : g_bad_cfg
         $error("line_evt_irq: NUM_CH and CFG_W must be at least 1");
      end
   endgenerate

   logic [NIN:0]      syn;
   logic [NIN-1:0]    lvl, prev_q, fall;
   logic [NUM_CH-1:0] det_lvl, alm_lvl, det_fall, alm_fall;
   logic [NUM_CH-1:0] det_stat, hold, det_evt, alm_stat_q;
   logic              pdn_act, tick, all_prev_hi, all_hi, any_hold, evt;
   logic              irq_n_q;
   logic [NUM_CH*STAT_W-1:0] rd_q;

   lei_sync #(.W(NIN + 1), .DEPTH(SYNC_D)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({pdn_n_i, alm_n_i, det_n_i}),
      .q_o   (syn)
   );

   lei_tick #(.DIV(TICK_DIV)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   assign lvl     = syn[NIN-1:0];
   assign pdn_act = !syn[NIN];
   assign det_lvl = lvl[NUM_CH-1:0];
   assign alm_lvl = lvl[NIN-1:NUM_CH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q     <= '1;
         alm_stat_q <= '1;
      end else begin
         prev_q     <= lvl;
         alm_stat_q <= alm_lvl;
      end
   end

   assign fall        = prev_q & ~lvl;
   assign det_fall    = fall[NUM_CH-1:0];
   assign alm_fall    = fall[NIN-1:NUM_CH];
   assign all_prev_hi = &prev_q;
   assign all_hi      = &lvl;
   assign any_hold    = |hold;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         lei_debounce #(.CFG_W(CFG_W)) u_deb (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_i     (tick),
            .pdn_act_i  (pdn_act),
            .det_lvl_i  (det_lvl[c]),
            .det_fall_i (det_fall[c]),
            .qual_i     (all_prev_hi),
            .cfg_i      (deb_cfg_i[c*CFG_W +: CFG_W]),
            .det_stat_o (det_stat[c]),
            .hold_o     (hold[c]),
            .evt_o      (det_evt[c])
         );
      end
   endgenerate

   assign evt = pdn_act ? (|fall)
                        : ((|alm_fall) && all_prev_hi) || (|det_evt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     irq_n_q <= 1'b1;
      else if (evt)                   irq_n_q <= 1'b0;
      else if (all_hi && !any_hold)   irq_n_q <= 1'b1;
   end

   assign irq_n_o = irq_n_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= '1;
      end else if (rd_en_i) begin
         for (int c = 0; c < NUM_CH; c++) begin
            rd_q[c*STAT_W +: STAT_W] <= chan_stat_t'{alm: alm_stat_q[c], det: det_stat[c]};
         end
      end
   end

   assign rd_data_o = rd_q;

   p_pdn_fall_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pdn_act && (|fall)) |=> !irq_n_q);

   p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (all_hi && !any_hold) |=> irq_n_q);

   p_unqualified_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!pdn_act && irq_n_q && !all_prev_hi && !any_hold) |=> irq_n_q);

   p_alm_tracks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(alm_lvl) |=> (alm_stat_q == $past(alm_lvl)));
endmodule

// File: tb/line_evt_irq_tb.sv
module line_evt_irq_tb;
   localparam int unsigned NCH = 2;
   localparam int unsigned DIV = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] det_n = 2'b11;
   logic [1:0] alm_n = 2'b11;
   logic       pdn_n = 1'b1;
   logic [7:0] cfg = {4'd5, 4'd2};
   logic       rd_en = 1'b0;
   logic [3:0] rd_data;
   logic       irq_n;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   line_evt_irq #(.NUM_CH(NCH), .CFG_W(4), .TICK_DIV(DIV)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .det_n_i   (det_n),
      .alm_n_i   (alm_n),
      .pdn_n_i   (pdn_n),
      .deb_cfg_i (cfg),
      .rd_en_i   (rd_en),
      .rd_data_o (rd_data),
      .irq_n_o   (irq_n)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wn(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd(output logic [3:0] v);
      @(negedge clk); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
      v = rd_data;
   endtask

   task automatic idle();
      det_n = 2'b11; alm_n = 2'b11;
      wn(80);
   endtask

   task automatic t_reset();
      logic [3:0] v;
      chk("R1", "irq after reset", irq_n, 1);
      rd(v);
      chk("R1", "status after reset", v, 4'hF);
   endtask

   task automatic t_alm_status();
      logic [3:0] v;
      alm_n[1] = 1'b0;
      wn(4); rd(v);
      chk("R2", "alm1 status low", v[3], 0);
      chk("R2", "other bits high", v[2:0], 3'b111);
      alm_n[1] = 1'b1;
      wn(4); rd(v);
      chk("R2", "alm1 status back high", v[3], 1);
      idle();
   endtask

   task automatic t_alm_irq();
      alm_n[0] = 1'b0;
      wn(2);
      chk("R3", "irq not yet after 2 edges", irq_n, 1);
      wn(1);
      chk("R3", "irq low after 3 edges", irq_n, 0);
      alm_n[0] = 1'b1;
      wn(2);
      chk("R9", "irq still low after 2 edges", irq_n, 0);
      wn(1);
      chk("R9", "irq released after 3 edges", irq_n, 1);
      idle();
   endtask

   task automatic t_det_debounce();
      logic [3:0] v;
      det_n[0] = 1'b0;
      wn(6);
      chk("R5", "irq held during hold", irq_n, 1);
      rd(v);
      chk("R5", "det0 status held", v[0], 1);
      wn(37);
      chk("R6", "irq low after expiry", irq_n, 0);
      rd(v);
      chk("R6", "det0 status low after expiry", v[0], 0);
      det_n[0] = 1'b1;
      wn(3);
      chk("R9", "irq released after det rises", irq_n, 1);
      idle();
   endtask

   task automatic t_glitch();
      logic [3:0] v;
      det_n[0] = 1'b0;
      wn(4);
      det_n[0] = 1'b1;
      wn(5);
      chk("R5", "irq high during glitch hold", irq_n, 1);
      wn(40);
      chk("R6", "glitch raises no irq", irq_n, 1);
      rd(v);
      chk("R6", "det0 status high after glitch", v[0], 1);
      idle();
   endtask

   task automatic t_cfg_indep();
      logic [3:0] v;
      det_n = 2'b00;
      wn(36); rd(v);
      chk("R10", "ch0 expired at 38", v[0], 0);
      chk("R10", "ch1 still held at 38", v[2], 1);
      chk("R10", "irq from ch0", irq_n, 0);
      wn(30); rd(v);
      chk("R10", "ch1 expired at 70", v[2], 0);
      det_n = 2'b11;
      wn(3);
      chk("R9", "irq released, no hold", irq_n, 1);
      idle();
   endtask

   task automatic t_no_qual();
      logic [3:0] v;
      det_n[0] = 1'b0;
      wn(4);
      alm_n[1] = 1'b0;
      wn(4);
      det_n[0] = 1'b1;
      wn(4);
      chk("R4", "alm fall with det low: no irq", irq_n, 1);
      wn(41);
      chk("R4", "no irq after hold ends", irq_n, 1);
      rd(v);
      chk("R4", "alm1 low, det0 high", {v[3], v[0]}, 2'b01);
      idle();
   endtask

   task automatic t_pdn();
      logic [3:0] v;
      det_n[0] = 1'b0;
      wn(4);
      pdn_n = 1'b0;
      wn(6);
      chk("R8", "entering power-down raises no irq", irq_n, 1);
      rd(v);
      chk("R8", "hold cancelled, det0 low", v[0], 0);
      alm_n[1] = 1'b0;
      wn(3);
      chk("R7", "fall with det0 low raises irq", irq_n, 0);
      det_n = 2'b11; alm_n = 2'b11;
      wn(3);
      chk("R9", "irq released in power-down", irq_n, 1);
      det_n[1] = 1'b0;
      wn(2);
      chk("R8", "no irq yet after 2 edges", irq_n, 1);
      wn(1);
      chk("R8", "det1 irq with no debounce", irq_n, 0);
      rd(v);
      chk("R8", "det1 status follows pin", v[2], 0);
      det_n[1] = 1'b1;
      wn(4); rd(v);
      chk("R8", "det1 status back high", v[2], 1);
      pdn_n = 1'b1;
      idle();
   endtask

   initial begin
      wn(3);
      rst_n = 1'b1;
      wn(2);
      t_reset();
      t_alm_status();
      t_alm_irq();
      t_det_debounce();
      t_glitch();
      t_cfg_indep();
      t_no_qual();
      t_pdn();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule